// File: doc/BRIEF.md
# UART Interrupt Priority Identifier

This block ranks the interrupt conditions of one serial channel and names the most urgent one. The receiver and transmitter logic, the line status logic, the modem input logic and the bus decoder all sit outside it. Each of them reports a condition as a level or as a one-cycle pulse, and each reports the register accesses that clear a condition as one-cycle strobes. A six-bit enable vector picks which sources take part.

The block holds a six-bit identification code. It shows the enabled pending source with the highest priority, or the idle code when nothing is pending. The interrupt request is the OR of all enabled pending sources. It is gated by an output-enable bit, and it stays low in polled mode. Some sources clear when the identification code is read while that code names them. The code does not change for the whole length of such a read.

There is no streaming data path. All pins are plain control and status signals, so no valid/ready handshake applies.

Top module: `uirq_ident`

## Requirements
- R1: After reset, and whenever no enabled source is pending, `iid` reads 6'b000001. Bit 0 is set only in this idle state, and `irq` is low after reset.
- R2: The line-error source has the highest priority and shows 6'b000110 when enabled by `ie[2]`. It is pending while `err_any` is high, which tracks the level of that input. It is also pending after an `ovr_evt` pulse, until `lsr_rd` clears the overrun.
- R3: With `ie[0]` set, a latched timeout (set by `tmo_evt`, cleared by `rhr_rd`) shows 6'b001100. It ranks ahead of the receive-trigger level `rx_trig`, which shows 6'b000100. Both rank below the line-error source.
- R4: With `ie[1]` set, a `tx_evt` pulse latches the transmit-space source, which shows 6'b000010. It clears on `thr_wr`, or on an `iir_rd` that starts while `iid` shows 6'b000010.
- R5: With `ie[3]` set, an `mdm_evt` pulse latches the modem-change source, which shows 6'b000000. It ranks below transmit space, and `msr_rd` clears it.
- R6: With `ie[4]` set, an `xoff_det` or `spec_det` pulse makes `iid` show 6'b010000. The flow-stop kind clears only on `xon_det`, and an `iir_rd` leaves it in place. The special-character kind clears on an `iir_rd` that starts while `iid` shows 6'b010000.
- R7: With `ie[5]` set, a `flow_evt` pulse (RTS or CTS going inactive) latches the lowest-priority source, which shows 6'b100000. An `iir_rd` that starts while `iid` shows 6'b100000 clears it.
- R8: A source whose enable bit is 0 is neither shown in `iid` nor able to raise `irq`. Its latch still records events. When `ie[3:0]` is all zero, the block is in polled mode and `irq` stays low.
- R9: While `iir_rd` is high, `iid` holds its value. The code follows the pending sources again from the first edge after `iir_rd` falls.
- R10: `irq` is high exactly when `int_oe` is 1, `ie[3:0]` is not all zero, and at least one enabled source is pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ie | input | 6 | Source enables: 0 rx data/timeout, 1 tx space, 2 line error, 3 modem, 4 flow-stop/special, 5 RTS/CTS inactive |
| int_oe | input | 1 | Interrupt output enable |
| err_any | input | 1 | Level: an erroneous character remains in the RX FIFO |
| ovr_evt | input | 1 | Pulse: receiver overrun |
| tmo_evt | input | 1 | Pulse: RX stale-data timeout |
| rx_trig | input | 1 | Level: RX FIFO at or above trigger |
| tx_evt | input | 1 | Pulse: TX space reached trigger / holding register empty |
| mdm_evt | input | 1 | Pulse: modem input change |
| xoff_det | input | 1 | Pulse: flow-stop character(s) received |
| xon_det | input | 1 | Pulse: flow-resume character(s) received |
| spec_det | input | 1 | Pulse: special character received |
| flow_evt | input | 1 | Pulse: RTS or CTS went from active to inactive |
| iir_rd | input | 1 | Level: identification read in progress |
| rhr_rd | input | 1 | Strobe: receive holding register read |
| lsr_rd | input | 1 | Strobe: line status read |
| msr_rd | input | 1 | Strobe: modem status read |
| thr_wr | input | 1 | Strobe: transmit holding register write |
| iid | output | 6 | Identification code |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default six-bit enable and code widths. This brings all seven condition sources and every pairwise priority within reach through one enable vector. The bench can therefore stack sources that compete, such as modem change against transmit space, line error against timeout, and RTS/CTS against modem, and check that the correct one wins. It can also clear sources one at a time and watch the next one surface. Reads of the identification code are held for several cycles while a new event arrives, which shows the freeze and the clear-on-read rules together.

// File: rtl/uirq_pkg.sv
package uirq_pkg;
  localparam int ID_W   = 6;
  localparam int IE_W   = 6;
  localparam int N_LAT  = 7;
  localparam int N_SRC  = 7;

  // latch indices
  localparam int L_OVR  = 0;
  localparam int L_TMO  = 1;
  localparam int L_TX   = 2;
  localparam int L_MDM  = 3;
  localparam int L_XOFF = 4;
  localparam int L_SPEC = 5;
  localparam int L_FLOW = 6;

  // enable bit positions
  localparam int E_RX   = 0;
  localparam int E_TX   = 1;
  localparam int E_LINE = 2;
  localparam int E_MDM  = 3;
  localparam int E_XOFF = 4;
  localparam int E_FLOW = 5;

  localparam logic [ID_W-1:0] ID_IDLE = 6'b000001;
  localparam logic [ID_W-1:0] ID_LINE = 6'b000110;
  localparam logic [ID_W-1:0] ID_TMO  = 6'b001100;
  localparam logic [ID_W-1:0] ID_RXD  = 6'b000100;
  localparam logic [ID_W-1:0] ID_TX   = 6'b000010;
  localparam logic [ID_W-1:0] ID_MDM  = 6'b000000;
  localparam logic [ID_W-1:0] ID_XOFF = 6'b010000;
  localparam logic [ID_W-1:0] ID_FLOW = 6'b100000;

  // source rank: index 0 is the most urgent
  function automatic logic [ID_W-1:0] rank_code(input int idx);
    case (idx)
      0:       rank_code = ID_LINE;
      1:       rank_code = ID_TMO;
      2:       rank_code = ID_RXD;
      3:       rank_code = ID_TX;
      4:       rank_code = ID_MDM;
      5:       rank_code = ID_XOFF;
      default: rank_code = ID_FLOW;
    endcase
  endfunction
endpackage

// File: rtl/uirq_flag.sv
module uirq_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  // a set in the same cycle as a clear wins, so no event is lost
  always_ff @(posedge clk) begin
    if (!rst_n)     q_o <= 1'b0;
    else if (set_i) q_o <= 1'b1;
    else if (clr_i) q_o <= 1'b0;
  end
endmodule

// File: rtl/uirq_prio.sv
module uirq_prio
  import uirq_pkg::*;
#(
  parameter int NS = N_SRC,
  parameter int W  = ID_W
) (
  input  logic [NS-1:0] pend_i,
  output logic [W-1:0]  code_o,
  output logic          any_o
);
  always_comb begin
    code_o = ID_IDLE;
    // walk from least to most urgent so the most urgent one overrides
    for (int k = NS - 1; k >= 0; k--) begin
      if (pend_i[k]) code_o = rank_code(k);
    end
    any_o = |pend_i;
  end
endmodule

// File: rtl/uirq_ident.sv
module uirq_ident
  import uirq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [IE_W-1:0] ie,
  input  logic            int_oe,
  input  logic            err_any,
  input  logic            ovr_evt,
  input  logic            tmo_evt,
  input  logic            rx_trig,
  input  logic            tx_evt,
  input  logic            mdm_evt,
  input  logic            xoff_det,
  input  logic            xon_det,
  input  logic            spec_det,
  input  logic            flow_evt,
  input  logic            iir_rd,
  input  logic            rhr_rd,
  input  logic            lsr_rd,
  input  logic            msr_rd,
  input  logic            thr_wr,
  output logic [ID_W-1:0] iid,
  output logic            irq
);
  logic [N_LAT-1:0] lat_set, lat_clr, lat_q;
  logic [N_SRC-1:0] pend;
  logic [ID_W-1:0]  next_code;
  logic             any_pend;
  logic             rd_q, rd_start;

  always_ff @(posedge clk) begin
    if (!rst_n) rd_q <= 1'b0;
    else        rd_q <= iir_rd;
  end
  assign rd_start = iir_rd & ~rd_q;

  always_comb begin
    lat_set          = '0;
    lat_set[L_OVR]   = ovr_evt;
    lat_set[L_TMO]   = tmo_evt;
    lat_set[L_TX]    = tx_evt;
    lat_set[L_MDM]   = mdm_evt;
    lat_set[L_XOFF]  = xoff_det;
    lat_set[L_SPEC]  = spec_det;
    lat_set[L_FLOW]  = flow_evt;

    lat_clr          = '0;
    lat_clr[L_OVR]   = lsr_rd;
    lat_clr[L_TMO]   = rhr_rd;
    lat_clr[L_TX]    = thr_wr | (rd_start && iid == ID_TX);
    lat_clr[L_MDM]   = msr_rd;
    lat_clr[L_XOFF]  = xon_det;
    lat_clr[L_SPEC]  = rd_start && iid == ID_XOFF;
    lat_clr[L_FLOW]  = rd_start && iid == ID_FLOW;
  end

  for (genvar g = 0; g < N_LAT; g++) begin : g_lat
    uirq_flag u_flag (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (lat_set[g]),
      .clr_i (lat_clr[g]),
      .q_o   (lat_q[g])
    );
  end

  always_comb begin
    pend    = '0;
    pend[0] = ie[E_LINE] & (err_any | lat_q[L_OVR]);
    pend[1] = ie[E_RX]   & lat_q[L_TMO];
    pend[2] = ie[E_RX]   & rx_trig;
    pend[3] = ie[E_TX]   & lat_q[L_TX];
    pend[4] = ie[E_MDM]  & lat_q[L_MDM];
    pend[5] = ie[E_XOFF] & (lat_q[L_XOFF] | lat_q[L_SPEC]);
    pend[6] = ie[E_FLOW] & lat_q[L_FLOW];
  end

  uirq_prio u_prio (
    .pend_i (pend),
    .code_o (next_code),
    .any_o  (any_pend)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)      iid <= ID_IDLE;
    else if (!iir_rd) iid <= next_code;
  end

  assign irq = int_oe & (|ie[3:0]) & any_pend;
endmodule

// File: rtl/uirq_chk.sv
module uirq_chk
  import uirq_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic [IE_W-1:0] ie,
  input logic            int_oe,
  input logic            err_any,
  input logic            iir_rd,
  input logic [ID_W-1:0] iid,
  input logic            irq
);
  p_idle_alone_r1: assert property (@(posedge clk) disable iff (!rst_n)
    iid[0] |-> (iid[ID_W-1:1] == '0));

  p_line_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ie[E_LINE] & err_any & ~iir_rd) |-> (iid == ID_LINE));

  p_polled_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ie[3:0] == '0) |-> !irq);

  p_read_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (iir_rd && $past(iir_rd)) |-> $stable(iid));

  p_gate_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !int_oe |-> !irq);
endmodule

bind uirq_ident uirq_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .ie      (ie),
  .int_oe  (int_oe),
  .err_any (err_any),
  .iir_rd  (iir_rd),
  .iid     (iid),
  .irq     (irq)
);

// File: tb/sim_uirq_ident.sv
`timescale 1ns/1ps
module sim_uirq_ident;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [5:0] ie = '0;
  logic int_oe = 1'b0;
  logic err_any = 0, ovr_evt = 0, tmo_evt = 0, rx_trig = 0, tx_evt = 0;
  logic mdm_evt = 0, xoff_det = 0, xon_det = 0, spec_det = 0, flow_evt = 0;
  logic iir_rd = 0, rhr_rd = 0, lsr_rd = 0, msr_rd = 0, thr_wr = 0;
  logic [5:0] iid;
  logic irq;

  always #2.5 clk = ~clk;

  uirq_ident u0 (
    .clk(clk), .rst_n(rst_n), .ie(ie), .int_oe(int_oe),
    .err_any(err_any), .ovr_evt(ovr_evt), .tmo_evt(tmo_evt), .rx_trig(rx_trig),
    .tx_evt(tx_evt), .mdm_evt(mdm_evt), .xoff_det(xoff_det), .xon_det(xon_det),
    .spec_det(spec_det), .flow_evt(flow_evt), .iir_rd(iir_rd), .rhr_rd(rhr_rd),
    .lsr_rd(lsr_rd), .msr_rd(msr_rd), .thr_wr(thr_wr), .iid(iid), .irq(irq)
  );

  typedef struct {
    logic [5:0] id;
    logic       irq;
    bit         use_irq;
    string      tag;
  } exp_t;
  exp_t sbq[$];
  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  // monitor: compares queued expectations away from the active edge
  always @(negedge clk) begin
    while (sbq.size() > 0) begin
      exp_t e;
      e = sbq.pop_front();
      n_chk++;
      if (iid !== e.id || (e.use_irq && irq !== e.irq)) begin
        n_bad++;
        $display("FAIL %s: iid=%b irq=%b expected iid=%b irq=%b",
                 e.tag, iid, irq, e.id, e.irq);
      end
    end
  end

  task automatic expect_st(input logic [5:0] id, input logic ir, input string tag);
    sbq.push_back('{id, ir, 1'b1, tag});
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  // 0 ovr 1 tmo 2 tx 3 mdm 4 xoff 5 xon 6 spec 7 flow 8 rhr 9 lsr 10 msr 11 thr
  task automatic pulse(input int which);
    case (which)
      0: ovr_evt = 1;  1: tmo_evt = 1;  2: tx_evt = 1;   3: mdm_evt = 1;
      4: xoff_det = 1; 5: xon_det = 1;  6: spec_det = 1; 7: flow_evt = 1;
      8: rhr_rd = 1;   9: lsr_rd = 1;   10: msr_rd = 1;  default: thr_wr = 1;
    endcase
    @(negedge clk);
    {ovr_evt, tmo_evt, tx_evt, mdm_evt, xoff_det, xon_det} = '0;
    {spec_det, flow_evt, rhr_rd, lsr_rd, msr_rd, thr_wr} = '0;
    settle();
  endtask

  task automatic id_read(input logic [5:0] seen, input string tag);
    iir_rd = 1;
    sbq.push_back('{seen, 1'b0, 1'b0, tag});
    @(negedge clk);
    iir_rd = 0;
    settle();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    expect_st(6'b000001, 0, "R1 reset idle");
    settle();

    // disabled source is recorded but hidden (R8)
    pulse(2);
    expect_st(6'b000001, 0, "R8 tx hidden while disabled");
    settle();
    ie = 6'h3F; int_oe = 1;
    settle();
    expect_st(6'b000010, 1, "R4 tx space shown");
    settle();
    id_read(6'b000010, "R4 read returns tx code");
    expect_st(6'b000001, 0, "R4 cleared by id read");
    settle();
    pulse(2); pulse(11);
    expect_st(6'b000001, 0, "R4 cleared by thr write");
    settle();

    // modem vs tx priority (R5)
    pulse(3);
    expect_st(6'b000000, 1, "R5 modem code");
    settle();
    pulse(2);
    expect_st(6'b000010, 1, "R5 tx outranks modem");
    settle();
    pulse(11);
    expect_st(6'b000000, 1, "R5 modem resurfaces");
    settle();
    pulse(10);
    expect_st(6'b000001, 0, "R5 msr read clears");
    settle();

    // receive data and timeout (R3)
    rx_trig = 1; settle();
    expect_st(6'b000100, 1, "R3 rx trigger");
    settle();
    pulse(1);
    expect_st(6'b001100, 1, "R3 timeout outranks rx data");
    settle();
    err_any = 1; settle();
    expect_st(6'b000110, 1, "R2 line error outranks timeout");
    settle();
    err_any = 0; settle();
    pulse(8);
    expect_st(6'b000100, 1, "R3 rhr read clears timeout");
    settle();
    rx_trig = 0; settle();
    expect_st(6'b000001, 0, "R3 rx level gone");
    settle();

    // overrun (R2)
    pulse(0);
    expect_st(6'b000110, 1, "R2 overrun shown");
    settle();
    pulse(9);
    expect_st(6'b000001, 0, "R2 lsr read clears overrun");
    settle();

    // flow-stop and special (R6)
    pulse(4);
    expect_st(6'b010000, 1, "R6 flow-stop shown");
    settle();
    id_read(6'b010000, "R6 read of flow-stop code");
    expect_st(6'b010000, 1, "R6 flow-stop survives id read");
    settle();
    pulse(5);
    expect_st(6'b000001, 0, "R6 resume clears flow-stop");
    settle();
    pulse(6);
    expect_st(6'b010000, 1, "R6 special shown");
    settle();
    id_read(6'b010000, "R6 read of special code");
    expect_st(6'b000001, 0, "R6 special cleared by id read");
    settle();

    // RTS/CTS inactive (R7)
    pulse(7);
    expect_st(6'b100000, 1, "R7 flow pin shown");
    settle();
    pulse(3);
    expect_st(6'b000000, 1, "R7 modem outranks flow pin");
    settle();
    pulse(10);
    expect_st(6'b100000, 1, "R7 flow pin resurfaces");
    settle();
    int_oe = 0; settle();
    expect_st(6'b100000, 0, "R10 output gated off");
    settle();
    int_oe = 1; settle();
    id_read(6'b100000, "R7 read of flow pin code");
    expect_st(6'b000001, 0, "R7 cleared by id read");
    settle();

    // polled mode and disabled upper source (R8)
    pulse(4);
    ie = 6'b110000; settle();
    expect_st(6'b010000, 0, "R8 polled mode keeps irq low");
    settle();
    ie = 6'b101111; settle();
    expect_st(6'b000001, 0, "R8 disabled flow-stop hidden");
    settle();
    ie = 6'h3F; pulse(5);
    expect_st(6'b000001, 0, "R6 cleanup");
    settle();

    // freeze during a long read (R9)
    iir_rd = 1;
    @(negedge clk);
    mdm_evt = 1;
    @(negedge clk);
    mdm_evt = 0;
    @(negedge clk);
    expect_st(6'b000001, 1, "R9 code frozen during read");
    repeat (2) @(negedge clk);
    iir_rd = 0;
    settle();
    expect_st(6'b000000, 1, "R9 code updates after read");
    settle();
    pulse(10);
    expect_st(6'b000001, 0, "R10 irq drops when nothing pending");
    settle();

    repeat (3) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule